// File: doc/BRIEF.md
# Doorbell and Mailbox Register Block

This block is the device-side register window that a host processor reaches over a 32-bit memory-mapped bus, inside a 0x600-byte address space. The host uses it to hand commands to the local firmware and to collect their results. It rings an inbound doorbell to announce a command, and it loads a 64-bit command-mailbox address that the firmware side reads out. It then waits for an outbound status bit, which the firmware raises when it posts a command identifier and status word. The host acknowledges that bit through a separate clear address. An interrupt mask with its own set and clear addresses decides which outbound status bits drive the interrupt line.

Each doorbell and the mask have two addresses. The first one reads status and sets bits. The second one clears bits and reads back the same status. Host writes use the top byte as command pulses, and reading the same address returns different status flags. An error flag and a one-byte error code share the outbound doorbell word. While the error is pending, the low half of the mailbox address word returns two error parameter bytes. A controller-reset command returns all doorbell state to its power-up values and holds an initialisation-busy flag until the firmware releases it. The firmware side is a set of one-cycle strobes and input pulses, so a testbench can stand in for it.

Top module: `dbmb_regs`

## Requirements
- R1: After the synchronous reset, these reads return the following values: 0x214 returns 0x02000000, because initialisation-busy sits at bit 25. 0x22C returns 0x03000000, with both mask bits set. 0x208, 0x224, 0x510, 0x514 and 0x518 all return 0. The irq output is low and every firmware strobe is low.
- R2: A host write of bit 24 to 0x214 sets mailbox-full, which reads at bit 24 of 0x214. In the cycle after the write, it also pulses fw_hmb_cmd for one cycle. If mailbox-full is already set, that write bit is ignored and no strobe follows.
- R3: A fw_hw_post pulse does three things. It clears mailbox-full, and it sets hardware-status-available at bit 24 of 0x224. It also loads 0x518 with fw_cmd_stat in bits 31:16 and fw_cmd_id in bits 15:0. A fw_mem_post pulse sets memory-status-available at bit 25 of 0x224.
- R4: Writing a 1 to bit 24 at 0x228 clears hardware-status-available, and writing a 1 to bit 25 clears memory-status-available. A zero bit has no effect. Writes to 0x224 clear nothing. When a firmware post and a host clear land in the same cycle, the post wins.
- R5: Writing 1s to bits 24/25 at 0x22C sets the hardware/memory mask bits, and writing 1s to them at 0x230 clears them. Both addresses read back the mask in bits 25:24.
- R6: irq is high exactly when some status-available bit is set and its mask bit is clear. 0x208 returns these unmasked pending bits in bits 25:24.
- R7: The following writes each produce a one-cycle strobe in the cycle after the write. Bit 26 at 0x214 pulses fw_gen_irq. Bit 28 at 0x214 pulses fw_mmb_cmd. Bit 25 at 0x218 pulses fw_status_ack. Bit 25 written at 0x214 has no effect.
- R8: The 64-bit mailbox address takes its low word from writes to 0x510 and its high word from writes to 0x514. It reads back at those offsets and drives fw_mbox_addr.
- R9: A fw_err_raise pulse sets error-pending at bit 29 of 0x224, and 0x224 then shows fw_err_code in bits 7:0. While the error is pending, bits 7:0 of 0x510 return fw_err_p0 and bits 15:8 return fw_err_p1. Only a write at 0x228 with both bit 24 and bit 25 set clears error-pending.
- R10: A write of bit 27 at 0x214 is the controller reset, and any other bits in that write are ignored. It clears every status-available bit, mailbox-full, error-pending, the status word and the mailbox address. It sets both mask bits and sets initialisation-busy. It also pulses fw_ctl_reset in the cycle after the write. Initialisation-busy stays set until a fw_init_done pulse.
- R11: Reads of unmapped or misaligned offsets return 0, and writes to them change nothing. bus_rdata is 0 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe; bus_rdata is valid in the same cycle |
| bus_addr | input | 11 | Byte offset within the window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data |
| irq | output | 1 | Interrupt from unmasked status-available bits |
| fw_hmb_cmd | output | 1 | Strobe: a new command is in the hardware mailbox |
| fw_mmb_cmd | output | 1 | Strobe: a new command is in the memory mailbox ring |
| fw_gen_irq | output | 1 | Strobe: the host asked for a firmware interrupt |
| fw_status_ack | output | 1 | Strobe: the host acknowledged the posted status |
| fw_ctl_reset | output | 1 | Strobe: the host issued a controller reset |
| fw_mbox_addr | output | 64 | Command mailbox address |
| fw_hw_post | input | 1 | Firmware posts a hardware-mailbox status |
| fw_cmd_id | input | 16 | Command identifier loaded on a post |
| fw_cmd_stat | input | 16 | Command status loaded on a post |
| fw_mem_post | input | 1 | Firmware posts a memory-mailbox status |
| fw_init_done | input | 1 | Firmware finished initialisation |
| fw_err_raise | input | 1 | Firmware raises an error |
| fw_err_code | input | 8 | Error code captured on a raise |
| fw_err_p0 | input | 8 | First error parameter byte |
| fw_err_p1 | input | 8 | Second error parameter byte |

## Verification
The bench targets several corner cases, each of which shows a specific symptom when wrong. A second new-command write while the mailbox is full must produce no strobe; a design that re-arms would hand the firmware a phantom command. The clear addresses must only clear bits and the set addresses must only set them; a design that decodes the pair as one address would drop a status on a plain read-set write. The error flag must survive a single-bit acknowledge and must replace the low mailbox address bytes only while it is pending; a wrong design would lose the error or corrupt the address readback. The controller reset must override command bits written alongside it and must restore the masked, busy state, and a long pseudo-random phase mixes host writes with colliding firmware pulses to probe the priority rules.

// File: rtl/dbmb_pkg.sv
// Package: shared offsets, field positions and decode types for the
// doorbell/mailbox register window. Assumes a 32-bit word-aligned bus.
package dbmb_pkg;
    localparam int WIN_AW    = 11;          // byte address width of window
    localparam int BUS_W     = 32;          // host data width
    localparam int NUM_CH    = 2;           // status channels: 0 hw, 1 mem
    localparam int CMD_LSB   = 24;          // command byte starts here
    localparam int CMD_BITS  = 5;           // command bits 24..28 used
    localparam int ERR_BIT   = 29;          // error-pending position
    localparam int BYTE_W    = 8;
    localparam int CMD_ID_W  = 16;
    localparam int CMD_ST_W  = 16;
    localparam int MBA_WORDS = 2;           // 64-bit mailbox address
    localparam int MBA_W     = MBA_WORDS * BUS_W;

    // command-byte bit indices (relative to CMD_LSB)
    localparam int CB_HW_NEW  = 0;
    localparam int CB_ACK     = 1;
    localparam int CB_GEN     = 2;
    localparam int CB_RESET   = 3;
    localparam int CB_MEM_NEW = 4;

    // register offsets
    localparam logic [WIN_AW-1:0] OFS_ISR     = 11'h208;
    localparam logic [WIN_AW-1:0] OFS_IDB_SET = 11'h214;
    localparam logic [WIN_AW-1:0] OFS_IDB_CLR = 11'h218;
    localparam logic [WIN_AW-1:0] OFS_ODB_SET = 11'h224;
    localparam logic [WIN_AW-1:0] OFS_ODB_CLR = 11'h228;
    localparam logic [WIN_AW-1:0] OFS_MSK_SET = 11'h22C;
    localparam logic [WIN_AW-1:0] OFS_MSK_CLR = 11'h230;
    localparam logic [WIN_AW-1:0] OFS_MBA_LO  = 11'h510;
    localparam logic [WIN_AW-1:0] OFS_STAT    = 11'h518;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_ISR, SEL_IDB, SEL_ODB, SEL_MSK,
        SEL_MBA, SEL_STAT
    } rsel_e;

    typedef struct packed {
        logic idb_set;
        logic idb_clr;
        logic odb_clr;
        logic msk_set;
        logic msk_clr;
        logic [MBA_WORDS-1:0] mba;
    } wsel_t;
endpackage

// File: rtl/dbmb_decode.sv
// Module: address decoder. Turns a byte offset into a read selector and,
// when a write is present, one-hot write enables. Assumes word-aligned
// offsets; anything else is unmapped.
module dbmb_decode
    import dbmb_pkg::*;
(
    input  logic [WIN_AW-1:0] addr,
    input  logic              wr,
    output wsel_t             wsel,
    output rsel_e             rsel,
    output logic              mba_word   // which mailbox address word
);
    localparam int WORD_SH = $clog2(BUS_W / BYTE_W);

    logic [WIN_AW-1:0] mba_base;
    logic              in_mba;

    // purpose: detect the mailbox address words by range
    always_comb begin
        mba_base = addr - OFS_MBA_LO;
        in_mba   = (addr >= OFS_MBA_LO) &&
                   (mba_base < WIN_AW'(MBA_WORDS << WORD_SH)) &&
                   (addr[WORD_SH-1:0] == '0);
        mba_word = mba_base[WORD_SH];
    end

    // purpose: read selector and write enables from the offset
    always_comb begin
        rsel = SEL_NONE;
        wsel = '0;
        if (in_mba) begin
            rsel = SEL_MBA;
            wsel.mba[mba_word] = wr;
        end else begin
            unique case (addr)
                OFS_ISR:     rsel = SEL_ISR;
                OFS_IDB_SET: begin rsel = SEL_IDB; wsel.idb_set = wr; end
                OFS_IDB_CLR: begin rsel = SEL_IDB; wsel.idb_clr = wr; end
                OFS_ODB_SET: rsel = SEL_ODB;
                OFS_ODB_CLR: begin rsel = SEL_ODB; wsel.odb_clr = wr; end
                OFS_MSK_SET: begin rsel = SEL_MSK; wsel.msk_set = wr; end
                OFS_MSK_CLR: begin rsel = SEL_MSK; wsel.msk_clr = wr; end
                OFS_STAT:    rsel = SEL_STAT;
                default:     rsel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dbmb_doorbell.sv
// Module: doorbell, mask and error state plus the firmware strobes.
// Assumes at most one write enable is active per cycle. Controller reset
// overrides every other event in its cycle.
module dbmb_doorbell
    import dbmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  wsel_t               wsel,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic                fw_hw_post,
    input  logic                fw_mem_post,
    input  logic                fw_init_done,
    input  logic                fw_err_raise,
    input  logic [BYTE_W-1:0]   fw_err_code,
    input  logic [BYTE_W-1:0]   fw_err_p0,
    input  logic [BYTE_W-1:0]   fw_err_p1,
    output logic                ctl_rst,
    output logic                hmb_full,
    output logic                init_busy,
    output logic [NUM_CH-1:0]   avail,
    output logic [NUM_CH-1:0]   mask,
    output logic                err_pend,
    output logic [BYTE_W-1:0]   err_code,
    output logic [BYTE_W-1:0]   err_p0,
    output logic [BYTE_W-1:0]   err_p1,
    output logic                st_hmb,
    output logic                st_mmb,
    output logic                st_gen,
    output logic                st_ack,
    output logic                st_rst
);
    logic              new_cmd_ok;
    logic              err_clr;
    logic [NUM_CH-1:0] post;

    // purpose: decode command pulses from the host write
    always_comb begin
        ctl_rst    = wsel.idb_set & cmd[CB_RESET];
        new_cmd_ok = wsel.idb_set & cmd[CB_HW_NEW] & ~hmb_full & ~ctl_rst;
        err_clr    = wsel.odb_clr & cmd[CB_HW_NEW] & cmd[CB_ACK];
        post       = {fw_mem_post, fw_hw_post};
    end

    // purpose: hardware mailbox full flag
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_rst)   hmb_full <= 1'b0;
        else if (new_cmd_ok)     hmb_full <= 1'b1;
        else if (fw_hw_post)     hmb_full <= 1'b0;
    end

    // purpose: initialisation-busy flag, released by firmware
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_rst)   init_busy <= 1'b1;
        else if (fw_init_done)   init_busy <= 1'b0;
    end

    // purpose: one status-available bit and one mask bit per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n || ctl_rst)                 avail[ch] <= 1'b0;
            else if (post[ch])                     avail[ch] <= 1'b1;
            else if (wsel.odb_clr && cmd[ch])      avail[ch] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n || ctl_rst)                 mask[ch] <= 1'b1;
            else if (wsel.msk_set && cmd[ch])      mask[ch] <= 1'b1;
            else if (wsel.msk_clr && cmd[ch])      mask[ch] <= 1'b0;
        end
    end

    // purpose: error record captured from firmware
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_rst) begin
            err_pend <= 1'b0;
            err_code <= '0;
            err_p0   <= '0;
            err_p1   <= '0;
        end else if (fw_err_raise) begin
            err_pend <= 1'b1;
            err_code <= fw_err_code;
            err_p0   <= fw_err_p0;
            err_p1   <= fw_err_p1;
        end else if (err_clr) begin
            err_pend <= 1'b0;
        end
    end

    // purpose: registered one-cycle strobes to the firmware side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_hmb <= 1'b0;
            st_mmb <= 1'b0;
            st_gen <= 1'b0;
            st_ack <= 1'b0;
            st_rst <= 1'b0;
        end else begin
            st_hmb <= new_cmd_ok;
            st_mmb <= wsel.idb_set & cmd[CB_MEM_NEW] & ~ctl_rst;
            st_gen <= wsel.idb_set & cmd[CB_GEN] & ~ctl_rst;
            st_ack <= wsel.idb_clr & cmd[CB_ACK];
            st_rst <= ctl_rst;
        end
    end

    // a new-command strobe implies the mailbox is now full
    assert_full_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_hmb |-> hmb_full);

    // a post outside a reset leaves hardware status available
    assert_post_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_hw_post && !ctl_rst) |=> avail[0]);

    // a mask-set write leaves the addressed mask bits set
    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel.msk_set && cmd[0]) |=> mask[0]);

    // the reset strobe never comes with other host command strobes
    assert_rst_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_rst |-> !(st_hmb || st_mmb || st_gen));

    // a raised error is pending on the next cycle
    assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_err_raise && !ctl_rst) |=> err_pend);

    // initialisation-busy holds until released
    assert_init_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && !fw_init_done) |=> init_busy);
endmodule

// File: rtl/dbmb_mailbox.sv
// Module: 64-bit command mailbox address and the posted identifier/status
// word. Assumes a controller reset clears both.
module dbmb_mailbox
    import dbmb_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctl_rst,
    input  logic [MBA_WORDS-1:0]         mba_we,
    input  logic [BUS_W-1:0]             wdata,
    input  logic                         fw_hw_post,
    input  logic [CMD_ID_W-1:0]          fw_cmd_id,
    input  logic [CMD_ST_W-1:0]          fw_cmd_stat,
    output logic [MBA_W-1:0]             mba,
    output logic [CMD_ST_W+CMD_ID_W-1:0] stat_word
);
    // purpose: one register per mailbox address word
    for (genvar w = 0; w < MBA_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n || ctl_rst)  mba[w*BUS_W +: BUS_W] <= '0;
            else if (mba_we[w])     mba[w*BUS_W +: BUS_W] <= wdata;
        end
    end

    // purpose: posted command identifier and status
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_rst)  stat_word <= '0;
        else if (fw_hw_post)    stat_word <= {fw_cmd_stat, fw_cmd_id};
    end

    // a post outside a reset loads the status word
    assert_status_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_hw_post && !ctl_rst) |=> stat_word == $past({fw_cmd_stat, fw_cmd_id}));

    // a low-word write lands in the address register
    assert_mba_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mba_we[0] |=> mba[BUS_W-1:0] == $past(wdata));
endmodule

// File: rtl/dbmb_regs.sv
// Module: top of the doorbell/mailbox register window. Decodes host
// accesses, holds the state in two sub-blocks and muxes read data in the
// same cycle as bus_rd. Reads have no side effects.
module dbmb_regs
    import dbmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [10:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              fw_hmb_cmd,
    output logic              fw_mmb_cmd,
    output logic              fw_gen_irq,
    output logic              fw_status_ack,
    output logic              fw_ctl_reset,
    output logic [63:0]       fw_mbox_addr,
    input  logic              fw_hw_post,
    input  logic [15:0]       fw_cmd_id,
    input  logic [15:0]       fw_cmd_stat,
    input  logic              fw_mem_post,
    input  logic              fw_init_done,
    input  logic              fw_err_raise,
    input  logic [7:0]        fw_err_code,
    input  logic [7:0]        fw_err_p0,
    input  logic [7:0]        fw_err_p1
);
    wsel_t                         wsel;
    rsel_e                         rsel;
    logic                          mba_word;
    logic                          ctl_rst;
    logic                          hmb_full;
    logic                          init_busy;
    logic [NUM_CH-1:0]             avail;
    logic [NUM_CH-1:0]             mask;
    logic [NUM_CH-1:0]             pend;
    logic                          err_pend;
    logic [BYTE_W-1:0]             err_code;
    logic [BYTE_W-1:0]             err_p0;
    logic [BYTE_W-1:0]             err_p1;
    logic [MBA_W-1:0]              mba;
    logic [CMD_ST_W+CMD_ID_W-1:0]  stat_word;
    logic [BUS_W-1:0]              rd_word;

    dbmb_decode u_decode (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wsel     (wsel),
        .rsel     (rsel),
        .mba_word (mba_word)
    );

    dbmb_doorbell u_doorbell (
        .clk          (clk),
        .rst_n        (rst_n),
        .wsel         (wsel),
        .cmd          (bus_wdata[CMD_LSB +: CMD_BITS]),
        .fw_hw_post   (fw_hw_post),
        .fw_mem_post  (fw_mem_post),
        .fw_init_done (fw_init_done),
        .fw_err_raise (fw_err_raise),
        .fw_err_code  (fw_err_code),
        .fw_err_p0    (fw_err_p0),
        .fw_err_p1    (fw_err_p1),
        .ctl_rst      (ctl_rst),
        .hmb_full     (hmb_full),
        .init_busy    (init_busy),
        .avail        (avail),
        .mask         (mask),
        .err_pend     (err_pend),
        .err_code     (err_code),
        .err_p0       (err_p0),
        .err_p1       (err_p1),
        .st_hmb       (fw_hmb_cmd),
        .st_mmb       (fw_mmb_cmd),
        .st_gen       (fw_gen_irq),
        .st_ack       (fw_status_ack),
        .st_rst       (fw_ctl_reset)
    );

    dbmb_mailbox u_mailbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_rst     (ctl_rst),
        .mba_we      (wsel.mba),
        .wdata       (bus_wdata),
        .fw_hw_post  (fw_hw_post),
        .fw_cmd_id   (fw_cmd_id),
        .fw_cmd_stat (fw_cmd_stat),
        .mba         (mba),
        .stat_word   (stat_word)
    );

    // purpose: unmasked pending bits and the interrupt line
    always_comb begin
        pend = avail & ~mask;
        irq  = |pend;
    end

    // purpose: read data multiplexer, zero for unmapped offsets
    always_comb begin
        rd_word = '0;
        unique case (rsel)
            SEL_ISR:  rd_word[CMD_LSB +: NUM_CH] = pend;
            SEL_IDB: begin
                rd_word[CMD_LSB + CB_HW_NEW] = hmb_full;
                rd_word[CMD_LSB + CB_ACK]    = init_busy;
            end
            SEL_ODB: begin
                rd_word[CMD_LSB +: NUM_CH] = avail;
                rd_word[ERR_BIT]           = err_pend;
                if (err_pend) rd_word[BYTE_W-1:0] = err_code;
            end
            SEL_MSK:  rd_word[CMD_LSB +: NUM_CH] = mask;
            SEL_MBA: begin
                rd_word = mba[mba_word*BUS_W +: BUS_W];
                if (err_pend && !mba_word)
                    rd_word[2*BYTE_W-1:0] = {err_p1, err_p0};
            end
            SEL_STAT: rd_word = stat_word;
            default:  rd_word = '0;
        endcase
    end

    // purpose: gate read data with the read strobe
    always_comb begin
        bus_rdata    = bus_rd ? rd_word : '0;
        fw_mbox_addr = mba;
    end

    // unmapped reads return zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rsel == SEL_NONE) |-> bus_rdata == '0);

    // a status read is nonzero exactly when the interrupt is up
    assert_isr_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rsel == SEL_ISR) |-> ((bus_rdata != '0) == irq));
endmodule

// File: tb/test_dbmb_regs.sv
`timescale 1ns/1ps
module test_dbmb_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, fw_hmb_cmd, fw_mmb_cmd, fw_gen_irq, fw_status_ack, fw_ctl_reset;
    logic [63:0] fw_mbox_addr;
    logic        fw_hw_post = 1'b0, fw_mem_post = 1'b0, fw_init_done = 1'b0, fw_err_raise = 1'b0;
    logic [15:0] fw_cmd_id = '0, fw_cmd_stat = '0;
    logic [7:0]  fw_err_code = '0, fw_err_p0 = '0, fw_err_p1 = '0;

    int total = 0;
    int bad = 0;
    bit live = 0;

    always #2.5 clk = ~clk;

    dbmb_regs i_dbmb_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .fw_hmb_cmd(fw_hmb_cmd), .fw_mmb_cmd(fw_mmb_cmd),
        .fw_gen_irq(fw_gen_irq), .fw_status_ack(fw_status_ack),
        .fw_ctl_reset(fw_ctl_reset), .fw_mbox_addr(fw_mbox_addr),
        .fw_hw_post(fw_hw_post), .fw_cmd_id(fw_cmd_id), .fw_cmd_stat(fw_cmd_stat),
        .fw_mem_post(fw_mem_post), .fw_init_done(fw_init_done),
        .fw_err_raise(fw_err_raise), .fw_err_code(fw_err_code),
        .fw_err_p0(fw_err_p0), .fw_err_p1(fw_err_p1)
    );

    // ---------------- behavioural reference model ----------------
    bit        m_full, m_init = 1, m_ep;
    bit [1:0]  m_av, m_mk = 2'b11;
    bit [7:0]  m_ec, m_p0, m_p1;
    bit [63:0] m_mba;
    bit [31:0] m_stat;
    bit [4:0]  m_strb;  // {rst, ack, gen, mmb, hmb}

    task automatic model_clear();
        m_full = 0; m_init = 1; m_ep = 0; m_av = 0; m_mk = 2'b11;
        m_ec = 0; m_p0 = 0; m_p1 = 0; m_mba = 0; m_stat = 0;
    endtask

    always @(posedge clk) begin
        bit [31:0] d;
        int a;
        bit took;
        live = 1;
        d = bus_wdata;
        a = bus_addr;
        m_strb = 0;
        if (!rst_n) begin
            model_clear();
        end else if (bus_wr && a == 'h214 && d[27]) begin
            model_clear();
            m_strb[4] = 1;
        end else begin
            took = bus_wr && a == 'h214 && d[24] && !m_full;
            if (fw_hw_post) begin
                m_full = 0;
                m_stat = {fw_cmd_stat, fw_cmd_id};
            end
            if (took) begin m_full = 1; m_strb[0] = 1; end
            if (bus_wr && a == 'h214) begin
                m_strb[1] = d[28];
                m_strb[2] = d[26];
            end
            if (bus_wr && a == 'h218) m_strb[3] = d[25];
            if (bus_wr && a == 'h228) begin
                if (d[24]) m_av[0] = 0;
                if (d[25]) m_av[1] = 0;
                if (d[24] && d[25]) m_ep = 0;
            end
            if (fw_hw_post) m_av[0] = 1;
            if (fw_mem_post) m_av[1] = 1;
            if (fw_err_raise) begin
                m_ep = 1; m_ec = fw_err_code; m_p0 = fw_err_p0; m_p1 = fw_err_p1;
            end
            if (fw_init_done) m_init = 0;
            if (bus_wr && a == 'h22C) m_mk = m_mk | d[25:24];
            if (bus_wr && a == 'h230) m_mk = m_mk & ~d[25:24];
            if (bus_wr && a == 'h510) m_mba[31:0] = d;
            if (bus_wr && a == 'h514) m_mba[63:32] = d;
        end
    end

    function automatic bit [31:0] mread(int a);
        bit [31:0] r = 0;
        case (a)
            'h208: r[25:24] = m_av & ~m_mk;
            'h214, 'h218: begin r[24] = m_full; r[25] = m_init; end
            'h224, 'h228: begin
                r[25:24] = m_av; r[29] = m_ep;
                if (m_ep) r[7:0] = m_ec;
            end
            'h22C, 'h230: r[25:24] = m_mk;
            'h510: r = m_ep ? {m_mba[31:16], m_p1, m_p0} : m_mba[31:0];
            'h514: r = m_mba[63:32];
            'h518: r = m_stat;
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (live) begin
            chk("R6 irq", irq, |(m_av & ~m_mk));
            chk("R2 hmb strobe", fw_hmb_cmd, m_strb[0]);
            chk("R7 strobes", {fw_ctl_reset, fw_status_ack, fw_gen_irq, fw_mmb_cmd},
                m_strb[4:1]);
            chk("R8 mbox addr", fw_mbox_addr, m_mba);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(int a, bit [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 11'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = 11'(a);
        #1;
        chk(tag, bus_rdata, mread(a));
        bus_rd = 0;
    endtask

    task automatic rdx(int a, bit [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = 11'(a);
        #1;
        chk(tag, bus_rdata, exp);
        chk(tag, bus_rdata, mread(a));
        bus_rd = 0;
    endtask

    task automatic post(bit [15:0] id, bit [15:0] st);
        @(negedge clk);
        fw_hw_post = 1; fw_cmd_id = id; fw_cmd_stat = st;
        @(negedge clk);
        fw_hw_post = 0;
    endtask

    task automatic mem_post();
        @(negedge clk); fw_mem_post = 1;
        @(negedge clk); fw_mem_post = 0;
    endtask

    task automatic init_done();
        @(negedge clk); fw_init_done = 1;
        @(negedge clk); fw_init_done = 0;
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int addrs[12] = '{'h208, 'h214, 'h218, 'h224, 'h228, 'h22C, 'h230,
                          'h510, 'h514, 'h518, 'h300, 'h212};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rdx('h214, 32'h0200_0000, "R1 inbound");
        rdx('h22C, 32'h0300_0000, "R1 mask");
        rdx('h224, 0, "R1 outbound");
        rdx('h208, 0, "R1 isr");
        rdx('h510, 0, "R1 mba lo");
        rdx('h518, 0, "R1 status");
        chk("R1 irq", irq, 0);

        // R10 init release
        init_done();
        rdx('h214, 0, "R10 init released");

        // R5 unmask both
        wr('h230, 32'h0300_0000);
        rdx('h22C, 0, "R5 mask cleared");
        rdx('h230, 0, "R5 mask via clr addr");

        // R8 mailbox address
        wr('h510, 32'h89AB_CDEF);
        wr('h514, 32'h0123_4567);
        rdx('h510, 32'h89AB_CDEF, "R8 lo");
        rdx('h514, 32'h0123_4567, "R8 hi");
        chk("R8 port", fw_mbox_addr, 64'h0123_4567_89AB_CDEF);

        // R2 new command, second one ignored
        wr('h214, 32'h0100_0000);
        rdx('h214, 32'h0100_0000, "R2 full set");
        wr('h214, 32'h0100_0000);
        rdx('h214, 32'h0100_0000, "R2 still full");

        // R3 post
        post(16'h0005, 16'h00A1);
        rdx('h214, 0, "R3 full cleared");
        rdx('h224, 32'h0100_0000, "R3 hw avail");
        rdx('h518, 32'h00A1_0005, "R3 status word");
        chk("R6 irq up", irq, 1);
        rdx('h208, 32'h0100_0000, "R6 isr");

        // R6 mask hides it
        wr('h22C, 32'h0100_0000);
        chk("R6 irq masked", irq, 0);
        rdx('h208, 0, "R6 isr masked");
        wr('h230, 32'h0100_0000);

        // R4 acknowledge rules
        wr('h224, 32'h0100_0000);
        rdx('h224, 32'h0100_0000, "R4 set addr no clear");
        wr('h228, 32'h0200_0000);
        rdx('h224, 32'h0100_0000, "R4 other bit no clear");
        wr('h228, 32'h0100_0000);
        rdx('h224, 0, "R4 hw acked");
        mem_post();
        rdx('h224, 32'h0200_0000, "R3 mem avail");
        chk("R6 irq mem", irq, 1);
        wr('h228, 32'h0200_0000);
        rdx('h224, 0, "R4 mem acked");

        // R7 strobes
        wr('h214, 32'h1400_0000);
        wr('h218, 32'h0200_0000);
        wr('h214, 32'h0200_0000);
        rdx('h214, 0, "R7 ack at set addr ignored");

        // R9 error
        @(negedge clk);
        fw_err_raise = 1; fw_err_code = 8'h5A; fw_err_p0 = 8'h11; fw_err_p1 = 8'h22;
        @(negedge clk);
        fw_err_raise = 0;
        rdx('h224, 32'h2000_005A, "R9 pending");
        rdx('h510, 32'h89AB_2211, "R9 params");
        wr('h228, 32'h0100_0000);
        rdx('h224, 32'h2000_005A, "R9 single bit keeps");
        wr('h228, 32'h0300_0000);
        rdx('h224, 0, "R9 cleared");
        rdx('h510, 32'h89AB_CDEF, "R9 address back");

        // R11 unmapped
        wr('h300, 32'hFFFF_FFFF);
        wr('h212, 32'hFFFF_FFFF);
        wr('h5FC, 32'hFFFF_FFFF);
        rdx('h300, 0, "R11 unmapped");
        rdx('h212, 0, "R11 misaligned");
        rdx('h5FC, 0, "R11 top");
        rdx('h22C, 0, "R11 mask untouched");
        rdx('h214, 0, "R11 inbound untouched");
        @(negedge clk);
        bus_addr = 11'h510; #1;
        chk("R11 no rd strobe", bus_rdata, 0);

        // R10 controller reset with a new command alongside
        post(16'h0007, 16'h0002);
        wr('h214, 32'h0900_0000);
        rdx('h214, 32'h0200_0000, "R10 busy");
        rdx('h22C, 32'h0300_0000, "R10 masked");
        rdx('h224, 0, "R10 status cleared");
        rdx('h518, 0, "R10 word cleared");
        rdx('h514, 0, "R10 address cleared");
        repeat (5) @(negedge clk);
        rdx('h214, 32'h0200_0000, "R10 held busy");
        init_done();
        rdx('h214, 0, "R10 released");

        // mixed pseudo-random phase
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_wr = ($urandom % 3) == 0;
            bus_rd = ($urandom % 2) == 0;
            bus_addr = 11'(addrs[$urandom % 12]);
            bus_wdata = $urandom;
            if (bus_addr == 11'h214 && ($urandom % 40) != 0) bus_wdata[27] = 0;
            fw_hw_post = ($urandom % 7) == 0;
            fw_mem_post = ($urandom % 7) == 0;
            fw_init_done = ($urandom % 9) == 0;
            fw_err_raise = ($urandom % 11) == 0;
            fw_cmd_id = 16'($urandom); fw_cmd_stat = 16'($urandom);
            fw_err_code = 8'($urandom); fw_err_p0 = 8'($urandom); fw_err_p1 = 8'($urandom);
            #1;
            if (bus_rd) chk("R11 random read", bus_rdata, mread(bus_addr));
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; fw_hw_post = 0; fw_mem_post = 0;
        fw_init_done = 0; fw_err_raise = 0;
        for (int k = 0; k < 10; k++) rd(addrs[k], "R1 final sweep");
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule